// File: doc/BRIEF.md
# Half-Duplex Gap and Jam Timer

This block times a half-duplex Ethernet transmitter in units of bit-times. Every pulse on `bit_tick` marks one bit-time, and the block advances only on those pulses. Before the transmitter may start a frame, the block counts out an inter-packet gap. For an early part of that gap, called the blinder window, carrier on the medium sends the count back to zero. After the blinder window ends, carrier has no effect on the count. When the count completes, `tx_permit` rises. The transmitter then raises `tx_req` for the length of its frame. When `tx_req` falls, a fresh gap begins.

The link partner can be throttled by asserting `force_jam`. The block then produces jam bursts whose length is chosen by a 2-bit code. Idle gaps separate the bursts, and the bursts continue for as long as the request is held. Once the request drops, the block counts a separate jam-to-data gap and only then grants permission to send data.

All timing fields arrive packed in `cfg_word`. The block captures them on the rising edge of `port_en` and holds them while the port stays enabled. Every pin is a plain control or status level, so there is no stream interface and no back-pressure.

Top module: `hdj_timer`

## Requirements
- R1: While `port_en` is low, `state` is 0 (off), and `tx_permit` and `jam_active` are low. One clock after `port_en` falls, the block is back in the off state.
- R2: `cfg_word` is captured once, at the rising edge of `port_en`. Changes to `cfg_word` while the port is enabled have no effect on any timing.
- R3: The data gap lasts 4×`cfg_word[4:0]` bit-ticks. A field value below 3 is treated as 3, giving a minimum of 12. `tx_permit` rises on the tick that completes this count, and clock cycles without `bit_tick` do not advance any count.
- R4: Carrier on a tick where the gap count is below 4×`cfg_word[9:5]` restarts the gap. A blinder field value below 3 is treated as 3. Carrier on any later tick of the gap is ignored.
- R5: In the ready state, a tick with `tx_req` high enters the send state (3), and `tx_permit` stays high. A tick with `tx_req` low in the send state starts a new gap. A tick with carrier in the ready state, when `tx_req` is low, also returns the block to the gap state.
- R6: A tick with `force_jam` high in the gap, ready or jam-to-data state enters the jam state (4), and `jam_active` goes high.
- R7: A jam burst lasts L×`JAM_UNIT` ticks, where L is 12, 24, 32 or 48 for `cfg_word[21:20]` = 0, 1, 2 or 3.
- R8: While `force_jam` stays high, bursts repeat, each followed by a gap of 4×`cfg_word[14:10]` ticks (a field value of 0 counts as 4 ticks). If `force_jam` is low on a tick during that gap, the block moves to the jam-to-data state (6).
- R9: If `force_jam` is low when a burst ends, the block enters the jam-to-data state. It raises `tx_permit` after 4×`cfg_word[19:15]` ticks, and a field value of 0 counts as 4 ticks.
- R10: The `state` encoding is: 0 off, 1 gap, 2 ready, 3 send, 4 jam, 5 jam gap, 6 jam-to-data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit-time |
| port_en | input | 1 | Port enable; rising edge captures configuration |
| cfg_word | input | 22 | Packed timing fields (see R3, R4, R7 to R9) |
| crs | input | 1 | Carrier sense |
| tx_req | input | 1 | Transmitter is sending a frame |
| force_jam | input | 1 | Backpressure jam request |
| tx_permit | output | 1 | Data transmission allowed |
| jam_active | output | 1 | Jam burst in progress |
| state | output | 3 | Current state (R10 encoding) |

## Verification
The gap function is tried in three ways: a quiet medium, carrier on the last tick inside the blinder window, and carrier on the first tick after the window. The first tick after permission is granted is measured in each case. Comparing the inside and outside cases pins the window boundary to a single tick. Field values below the clamp limits show whether each minimum is applied.

Jam tests cover the four length codes and a held request that yields several bursts. They also cover dropping the request during a burst and during the gap between bursts, which separates the two exit paths into the jam-to-data gap. A configuration change made while the port is enabled, followed by a frame, checks that the gap still uses the value captured at enable.

// File: rtl/hdj_pkg.sv
`timescale 1ns/1ps
package hdj_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_GAP   = 3'd1,
    ST_READY = 3'd2,
    ST_SEND  = 3'd3,
    ST_JAM   = 3'd4,
    ST_JGAP  = 3'd5,
    ST_J2D   = 3'd6
  } hdj_state_e;

  typedef struct packed {
    logic [1:0] jam_code;
    logic [4:0] j2d_steps;
    logic [4:0] jgap_steps;
    logic [4:0] blind_nib;
    logic [4:0] ipg_steps;
  } hdj_cfg_t;

  localparam int CFG_W    = $bits(hdj_cfg_t);
  localparam int MIN_IPG  = 3;
  localparam int MIN_BLND = 3;
endpackage

// File: rtl/hdj_cfg_reg.sv
`timescale 1ns/1ps
module hdj_cfg_reg import hdj_pkg::*; #(
  parameter int JAM_UNIT = 1024,
  parameter int CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  hdj_cfg_t      cfg_in,
  output logic          cfg_valid,
  output logic [CW-1:0] ipg_len,
  output logic [CW-1:0] blind_len,
  output logic [CW-1:0] jgap_len,
  output logic [CW-1:0] j2d_len,
  output logic [CW-1:0] jam_len
);
  logic [4:0]    ipg_f, blind_f, jgap_f, j2d_f;
  logic [CW-1:0] jam_sel;

  always_comb begin
    ipg_f   = (cfg_in.ipg_steps < 5'(MIN_IPG))  ? 5'(MIN_IPG)  : cfg_in.ipg_steps;
    blind_f = (cfg_in.blind_nib < 5'(MIN_BLND)) ? 5'(MIN_BLND) : cfg_in.blind_nib;
    jgap_f  = (cfg_in.jgap_steps == 5'd0) ? 5'd1 : cfg_in.jgap_steps;
    j2d_f   = (cfg_in.j2d_steps  == 5'd0) ? 5'd1 : cfg_in.j2d_steps;
    case (cfg_in.jam_code)
      2'd0:    jam_sel = CW'(12 * JAM_UNIT);
      2'd1:    jam_sel = CW'(24 * JAM_UNIT);
      2'd2:    jam_sel = CW'(32 * JAM_UNIT);
      default: jam_sel = CW'(48 * JAM_UNIT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_valid <= 1'b0;
      ipg_len   <= '0;
      blind_len <= '0;
      jgap_len  <= '0;
      j2d_len   <= '0;
      jam_len   <= '0;
    end else begin
      cfg_valid <= port_en;
      if (port_en && !cfg_valid) begin
        ipg_len   <= CW'({ipg_f,   2'b00});
        blind_len <= CW'({blind_f, 2'b00});
        jgap_len  <= CW'({jgap_f,  2'b00});
        j2d_len   <= CW'({j2d_f,   2'b00});
        jam_len   <= jam_sel;
      end
    end
  end
endmodule

// File: rtl/hdj_fsm.sv
`timescale 1ns/1ps
module hdj_fsm import hdj_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          port_en,
  input  logic          cfg_valid,
  input  logic          crs,
  input  logic          tx_req,
  input  logic          force_jam,
  input  logic [CW-1:0] ipg_len,
  input  logic [CW-1:0] blind_len,
  input  logic [CW-1:0] jgap_len,
  input  logic [CW-1:0] j2d_len,
  input  logic [CW-1:0] jam_len,
  output hdj_state_e    st
);
  hdj_state_e    st_n;
  logic [CW-1:0] cnt, cnt_n, cnt_inc;

  assign cnt_inc = cnt + CW'(1);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (!port_en) begin
      st_n  = ST_OFF;
      cnt_n = '0;
    end else if (st == ST_OFF) begin
      if (cfg_valid) begin
        st_n  = ST_GAP;
        cnt_n = '0;
      end
    end else if (bit_tick) begin
      case (st)
        ST_GAP: begin
          if (force_jam) begin
            st_n = ST_JAM; cnt_n = '0;
          end else if (crs && (cnt < blind_len)) begin
            cnt_n = '0;
          end else if (cnt_inc >= ipg_len) begin
            st_n = ST_READY; cnt_n = '0;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        ST_READY: begin
          if (force_jam) begin
            st_n = ST_JAM; cnt_n = '0;
          end else if (tx_req) begin
            st_n = ST_SEND;
          end else if (crs) begin
            st_n = ST_GAP; cnt_n = '0;
          end
        end
        ST_SEND: begin
          if (!tx_req) begin
            st_n = ST_GAP; cnt_n = '0;
          end
        end
        ST_JAM: begin
          if (cnt_inc >= jam_len) begin
            st_n  = force_jam ? ST_JGAP : ST_J2D;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        ST_JGAP: begin
          if (!force_jam) begin
            st_n = ST_J2D; cnt_n = '0;
          end else if (cnt_inc >= jgap_len) begin
            st_n = ST_JAM; cnt_n = '0;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        ST_J2D: begin
          if (force_jam) begin
            st_n = ST_JAM; cnt_n = '0;
          end else if (cnt_inc >= j2d_len) begin
            st_n = ST_READY; cnt_n = '0;
          end else begin
            cnt_n = cnt_inc;
          end
        end
        default: begin
          st_n = ST_OFF; cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/hdj_timer.sv
`timescale 1ns/1ps
module hdj_timer import hdj_pkg::*; #(
  parameter int JAM_UNIT = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 port_en,
  input  logic [CFG_W-1:0]     cfg_word,
  input  logic                 crs,
  input  logic                 tx_req,
  input  logic                 force_jam,
  output logic                 tx_permit,
  output logic                 jam_active,
  output logic [2:0]           state
);
  localparam int CW_JAM = $clog2(48 * JAM_UNIT + 1);
  localparam int CW     = (CW_JAM > 7) ? CW_JAM : 7;

  logic          cfg_valid;
  logic [CW-1:0] ipg_len, blind_len, jgap_len, j2d_len, jam_len;
  hdj_state_e    st;
  hdj_cfg_t      cfg_s;

  assign cfg_s = hdj_cfg_t'(cfg_word);

  hdj_cfg_reg #(.JAM_UNIT(JAM_UNIT), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_in(cfg_s),
    .cfg_valid(cfg_valid), .ipg_len(ipg_len), .blind_len(blind_len),
    .jgap_len(jgap_len), .j2d_len(j2d_len), .jam_len(jam_len)
  );

  hdj_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .port_en(port_en),
    .cfg_valid(cfg_valid), .crs(crs), .tx_req(tx_req), .force_jam(force_jam),
    .ipg_len(ipg_len), .blind_len(blind_len), .jgap_len(jgap_len),
    .j2d_len(j2d_len), .jam_len(jam_len), .st(st)
  );

  assign state      = st;
  assign tx_permit  = (st == ST_READY) || (st == ST_SEND);
  assign jam_active = (st == ST_JAM);
endmodule

// File: rtl/hdj_timer_chk.sv
`timescale 1ns/1ps
module hdj_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          port_en,
  input logic          cfg_valid,
  input logic          force_jam,
  input logic          tx_req,
  input logic          tx_permit,
  input logic          jam_active,
  input logic [2:0]    state,
  input logic [CW-1:0] ipg_len,
  input logic [CW-1:0] jam_len
);
  // R1: disabling the port returns to off with outputs low
  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (state == 3'd0) && !tx_permit && !jam_active);

  // R2: captured lengths do not move while the port stays enabled
  p_cfg_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && $past(cfg_valid) && $past(port_en)) |-> ($stable(ipg_len) && $stable(jam_len)));

  // R3: without a tick, an active state does not change
  p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && port_en && state != 3'd0) |=> $stable(state));

  // R3/R9: permission is granted only from the gap or jam-to-data state
  p_permit_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_permit) |-> ($past(state) == 3'd1 || $past(state) == 3'd6));

  // R6: a burst only starts under a jam request
  p_jam_needs_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> $past(force_jam));

  // R5: entering send requires a transmit request
  p_send_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && $past(state) != 3'd3) |-> $past(tx_req));
endmodule

bind hdj_timer hdj_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .port_en(port_en),
  .cfg_valid(cfg_valid), .force_jam(force_jam), .tx_req(tx_req),
  .tx_permit(tx_permit), .jam_active(jam_active), .state(state),
  .ipg_len(ipg_len), .jam_len(jam_len)
);

// File: tb/hdj_timer_test.sv
`timescale 1ns/1ps
module hdj_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        port_en = 1'b0;
  logic [21:0] cfg_word = '0;
  logic        crs = 1'b0;
  logic        tx_req = 1'b0;
  logic        force_jam = 1'b0;
  logic        tx_permit, jam_active;
  logic [2:0]  state;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  hdj_timer #(.JAM_UNIT(1)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .port_en(port_en),
    .cfg_word(cfg_word), .crs(crs), .tx_req(tx_req), .force_jam(force_jam),
    .tx_permit(tx_permit), .jam_active(jam_active), .state(state)
  );

  always #2.5 clk = ~clk;

  // {ipg field, blinder field, carrier tick (0 = none), ticks until permit}
  localparam int VEC [8][4] = '{
    '{3,  3,  0,   12},
    '{24, 16, 0,   96},
    '{24, 16, 64,  160},
    '{24, 16, 65,  96},
    '{0,  3,  0,   12},
    '{5,  1,  12,  32},
    '{5,  1,  13,  20},
    '{31, 31, 100, 224}
  };

  function automatic logic [21:0] mkcfg(int ipg, int bl, int jg, int jd, int code);
    return {2'(code), 5'(jd), 5'(jg), 5'(bl), 5'(ipg)};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(int act, int exp, string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(bit c);
    @(negedge clk); bit_tick = 1'b1; crs = c;
    @(negedge clk); bit_tick = 1'b0; crs = 1'b0;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic enable_with(logic [21:0] c);
    @(negedge clk); port_en = 1'b0;
    cycles(3);
    cfg_word = c; port_en = 1'b1;
    cycles(3);
  endtask

  // mode 0: until state==v, 1: until state!=v, 2: until tx_permit
  task automatic run_until(int mode, int v, output int n);
    bit hit;
    n = 0; hit = 1'b0;
    while (!hit && n < 500) begin
      tick(1'b0); n++;
      case (mode)
        0: hit = (int'(state) == v);
        1: hit = (int'(state) != v);
        default: hit = tx_permit;
      endcase
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int n;
    cycles(4);
    chk(int'(state), 0, "R1 reset state");
    chk(int'(tx_permit), 0, "R1 reset permit");
    chk(int'(jam_active), 0, "R1 reset jam");
    rst_n = 1'b1;
    cycles(2);
    for (int i = 0; i < 5; i++) tick(1'b0);
    chk(int'(state), 0, "R1 disabled stays off");

    // Table: gap length, clamping and blinder window
    for (int i = 0; i < 8; i++) begin
      bit got;
      enable_with(mkcfg(VEC[i][0], VEC[i][1], 2, 3, 0));
      n = 0; got = 1'b0;
      while (!got && n < 400) begin
        n++;
        tick(VEC[i][2] == n);
        got = tx_permit;
      end
      chk(n, VEC[i][3], (VEC[i][2] == 0) ? "R3 gap length" : "R4 blinder");
    end

    // R5 send path, R2 config change ignored while enabled
    enable_with(mkcfg(3, 3, 2, 3, 0));
    run_until(2, 0, n);
    chk(n, 12, "R3 base gap");
    chk(int'(state), 2, "R10 ready code");
    cfg_word = mkcfg(31, 31, 2, 3, 3);
    tx_req = 1'b1; tick(1'b0);
    chk(int'(state), 3, "R5 send entered");
    chk(int'(tx_permit), 1, "R5 permit in send");
    tx_req = 1'b0; tick(1'b0);
    chk(int'(state), 1, "R5 back to gap");
    chk(int'(tx_permit), 0, "R5 permit dropped");
    run_until(2, 0, n);
    chk(n, 12, "R2 captured gap kept");
    tick(1'b1);
    chk(int'(state), 1, "R5 carrier in ready defers");

    // R1 disable mid-gap
    @(negedge clk); port_en = 1'b0;
    @(negedge clk);
    chk(int'(state), 0, "R1 off after disable");

    // R6..R9 jam sequence, code 0, jam gap 8, jam-to-data 12
    enable_with(mkcfg(3, 3, 2, 3, 0));
    run_until(2, 0, n);
    force_jam = 1'b1; tick(1'b0);
    chk(int'(state), 4, "R6 jam from ready");
    chk(int'(jam_active), 1, "R6 jam active");
    run_until(1, 4, n);
    chk(n, 12, "R7 code0 length");
    chk(int'(state), 5, "R8 jam gap state");
    run_until(0, 4, n);
    chk(n, 8, "R8 gap between bursts");
    force_jam = 1'b0;
    run_until(1, 4, n);
    chk(n, 12, "R7 burst completes");
    chk(int'(state), 6, "R9 jam-to-data state");
    run_until(2, 0, n);
    chk(n, 12, "R9 jam-to-data length");

    // R7 other length codes
    for (int c = 1; c < 4; c++) begin
      int exp_len;
      exp_len = (c == 1) ? 24 : (c == 2) ? 32 : 48;
      enable_with(mkcfg(3, 3, 2, 3, c));
      run_until(2, 0, n);
      force_jam = 1'b1; tick(1'b0);
      force_jam = 1'b0;
      run_until(1, 4, n);
      chk(n, exp_len, "R7 length code");
    end

    // R8 zero jam gap field, then clear during the gap
    enable_with(mkcfg(3, 3, 0, 1, 0));
    run_until(2, 0, n);
    force_jam = 1'b1; tick(1'b0);
    run_until(1, 4, n);
    run_until(0, 4, n);
    chk(n, 4, "R8 zero field gap");
    run_until(0, 5, n);
    force_jam = 1'b0; tick(1'b0);
    chk(int'(state), 6, "R8 clear during gap");

    // R6 force jam from gap state
    enable_with(mkcfg(3, 3, 2, 3, 0));
    tick(1'b0); tick(1'b0);
    chk(int'(state), 1, "R10 gap code");
    force_jam = 1'b1; tick(1'b0);
    chk(int'(state), 4, "R6 jam from gap");
    force_jam = 1'b0;

    cycles(4);
    report();
  end
endmodule